// File: doc/BRIEF.md
# DAC Core Control Register Block

This block is the software-facing control plane of a multi-channel digital-to-analog datapath. A host reads and writes 32-bit words over a simple byte-addressed bus with separate write and read strobes. Read data returns one cycle after the read strobe. The block holds a small set of global controls: a two-bit reset release word, a channel-sync strobe and a stream-sharing mode bit. It also holds a read-only configuration word and a status word that reports clock-manager lock. Above these sits a bank of per-channel register windows.

The datapath is taken out of reset in a fixed sequence. First the clock-manager reset is released. Once the lock input (brought in through a two-flop synchroniser) is high, both release bits are set. The core reset output only deasserts while both bits are set and the synchronised lock is high, so a lost lock puts the core back into reset. Each channel window holds four 32-bit tone-parameter words and a 4-bit source-select field. All of these are driven out as flat buses to the datapath. After changing tone parameters, software fires the sync strobe so that every channel picks up the new values on the same cycle.

Top module: `dac_ctrl_regs`

## Requirements
- R1: After reset, every writable register reads 0. `clkmgr_rst_n`, `core_rst_n`, `sync_pulse`, `indep_mode` and `rvalid` are all 0, and every channel source select is 0.
- R2: The reset-release word sits at byte address 0x040. Bit 1 drives `clkmgr_rst_n` directly. `core_rst_n` is 1 only while bit 0 and bit 1 are both 1 and the synchronised lock is 1. Writing 0 drives both outputs low in the cycle after the write. Only bits 1:0 are stored and read back.
- R3: `lock_in` passes through two flops before it is used. It is reported in bit 17 of the status word at 0x074, and a change on `lock_in` reaches `core_rst_n` on the second rising edge after it.
- R4: Writing 1 to bit 0 of the word at 0x044 makes `sync_pulse` high for exactly the one cycle after the write. The bit clears itself and reads back 0. Writing 0 to this bit produces no pulse.
- R5: Bit 4 of the word at 0x048 is stored, read back and driven on `indep_mode`, where 1 means independent channels and 0 means a shared stream. The other bits of this word read 0.
- R6: The word at 0x00C is read-only. Bit 6 equals parameter `TONE_ABSENT` and all other bits are 0. Writes to it change nothing.
- R7: Channel c has a window at 0x400 + 0x40*c. Words at window offsets 0x00, 0x04, 0x08 and 0x0C are full 32-bit read/write tone parameters. Word k of channel c appears on `ch_tone[(c*4+k)*32 +: 32]`.
- R8: Window offset 0x18 holds a 4-bit source select in bits 3:0, and bits 31:4 read 0. The field of channel c appears on `ch_data_sel[c*4 +: 4]`. Value 0 selects the internal tone generator and value 2 selects streamed data.
- R9: Reads of any address that maps to no register return 0. This covers window gaps and windows of channels at or above `NUM_CH`. Writes to such addresses change no register.
- R10: A read strobe in cycle n gives `rvalid` = 1 and the addressed word on `rdata` after the rising edge that ends cycle n. `rvalid` is 0 in every cycle after an edge without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 12 | Byte address; bits 1:0 ignored |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid |
| lock_in | input | 1 | Clock-manager lock, asynchronous |
| clkmgr_rst_n | output | 1 | Clock-manager reset release |
| core_rst_n | output | 1 | Datapath core reset release |
| sync_pulse | output | 1 | One-cycle channel update strobe |
| indep_mode | output | 1 | 1 = independent channels, 0 = shared stream |
| ch_data_sel | output | NUM_CH*4 | Per-channel source select |
| ch_tone | output | NUM_CH*128 | Per-channel tone parameter words |

## Verification
A register write and a change on the lock input can land in the same cycle. The critical case is a write that sets both release bits while the synchronised lock is still low. The bench sets both bits while `lock_in` is held low and checks that `core_rst_n` stays low. It then raises `lock_in` and checks that the output rises only on the second edge afterwards. It also drops lock while the core is released and checks that the core falls back into reset after the same two-edge delay, even though the register still reads 3.

// File: rtl/dac_ctrl_pkg.sv
package dac_ctrl_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  // global word addresses
  localparam logic [ADDR_W-1:0] A_CFG   = 12'h00C;
  localparam logic [ADDR_W-1:0] A_RST   = 12'h040;
  localparam logic [ADDR_W-1:0] A_CTRL1 = 12'h044;
  localparam logic [ADDR_W-1:0] A_CTRL2 = 12'h048;
  localparam logic [ADDR_W-1:0] A_STAT  = 12'h074;

  // channel windows: 0x400..0x7FF, 0x40 bytes each
  localparam int WIN_LG     = 6;
  localparam int WIDX_W     = WIN_LG - 2;
  localparam int CHIDX_W    = 4;
  localparam int TONE_WORDS = 4;
  localparam int SEL_W      = 4;
  localparam int SEL_WORD   = 6;

  // bit positions
  localparam int B_NOTONE = 6;
  localparam int B_MODE   = 4;
  localparam int B_LOCK   = 17;

  typedef enum logic [SEL_W-1:0] {
    SRC_TONE   = 4'd0,
    SRC_STREAM = 4'd2
  } src_sel_e;

  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:ADDR_W-2] == 2'b01;
  endfunction
endpackage

// File: rtl/dac_lock_sync.sv
module dac_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], din};
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/dac_chan_bank.sv
module dac_chan_bank
  import dac_ctrl_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [WIDX_W-1:0]            widx,
  input  logic [DATA_W-1:0]            wdata,
  input  logic [WIDX_W-1:0]            ridx,
  output logic [DATA_W-1:0]            rd_word,
  output logic [TONE_WORDS*DATA_W-1:0] tone_flat,
  output logic [SEL_W-1:0]             sel
);
  logic [DATA_W-1:0] tone_q [TONE_WORDS];
  logic [SEL_W-1:0]  sel_q;

  for (genvar w = 0; w < TONE_WORDS; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               tone_q[w] <= '0;
      else if (wr_en && widx == WIDX_W'(w))     tone_q[w] <= wdata;
    end
    assign tone_flat[w*DATA_W +: DATA_W] = tone_q[w];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 sel_q <= SRC_TONE;
    else if (wr_en && widx == WIDX_W'(SEL_WORD)) sel_q <= wdata[SEL_W-1:0];
  end

  assign sel = sel_q;

  always_comb begin
    rd_word = '0;
    for (int w = 0; w < TONE_WORDS; w++)
      if (ridx == WIDX_W'(w)) rd_word = tone_q[w];
    if (ridx == WIDX_W'(SEL_WORD)) rd_word = {{(DATA_W-SEL_W){1'b0}}, sel_q};
  end
endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
  import dac_ctrl_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter bit TONE_ABSENT = 1'b0
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic                                rd_en,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [DATA_W-1:0]                   wdata,
  output logic [DATA_W-1:0]                   rdata,
  output logic                                rvalid,
  input  logic                                lock_in,
  output logic                                clkmgr_rst_n,
  output logic                                core_rst_n,
  output logic                                sync_pulse,
  output logic                                indep_mode,
  output logic [NUM_CH*SEL_W-1:0]             ch_data_sel,
  output logic [NUM_CH*TONE_WORDS*DATA_W-1:0] ch_tone
);
  localparam int TONE_BUS = TONE_WORDS * DATA_W;

  logic [ADDR_W-1:0]  wa;
  logic [CHIDX_W-1:0] ch_idx;
  logic [WIDX_W-1:0]  w_idx;
  logic               win_hit;
  logic               unused_addr;

  assign wa          = {addr[ADDR_W-1:2], 2'b00};
  assign ch_idx      = addr[WIN_LG+CHIDX_W-1:WIN_LG];
  assign w_idx       = addr[WIN_LG-1:2];
  assign win_hit     = in_window(addr) && (32'(ch_idx) < NUM_CH);
  assign unused_addr = ^addr[1:0];

  // global registers
  logic [1:0] rst_q;
  logic       sync_q;
  logic       mode_q;
  logic       lock_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= '0;
      sync_q <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      sync_q <= wr_en && wa == A_CTRL1 && wdata[0];
      if (wr_en && wa == A_RST)   rst_q  <= wdata[1:0];
      if (wr_en && wa == A_CTRL2) mode_q <= wdata[B_MODE];
    end
  end

  dac_lock_sync #(.STAGES(2)) u_lock_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (lock_in),
    .dout (lock_s)
  );

  assign clkmgr_rst_n = rst_q[1];
  assign core_rst_n   = rst_q[1] & rst_q[0] & lock_s;
  assign sync_pulse   = sync_q;
  assign indep_mode   = mode_q;

  // channel windows
  logic [DATA_W-1:0] ch_rd [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic ch_wr;
    assign ch_wr = wr_en && win_hit && ch_idx == CHIDX_W'(c);

    dac_chan_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ch_wr),
      .widx     (w_idx),
      .wdata    (wdata),
      .ridx     (w_idx),
      .rd_word  (ch_rd[c]),
      .tone_flat(ch_tone[c*TONE_BUS +: TONE_BUS]),
      .sel      (ch_data_sel[c*SEL_W +: SEL_W])
    );
  end

  // read mux
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (win_hit) begin
      for (int c = 0; c < NUM_CH; c++)
        if (ch_idx == CHIDX_W'(c)) rd_mux = ch_rd[c];
    end else begin
      case (wa)
        A_CFG:   rd_mux[B_NOTONE] = TONE_ABSENT;
        A_RST:   rd_mux[1:0]      = rst_q;
        A_CTRL1: rd_mux[0]        = sync_q;
        A_CTRL2: rd_mux[B_MODE]   = mode_q;
        A_STAT:  rd_mux[B_LOCK]   = lock_s;
        default: rd_mux           = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dac_ctrl_regs_chk.sv
module dac_ctrl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic [11:0] addr,
  input logic        wdata0,
  input logic        lock_in,
  input logic        clkmgr_rst_n,
  input logic        core_rst_n,
  input logic        sync_pulse,
  input logic        rvalid
);
  // R2: core release never precedes clock-manager release
  p_core_after_clkmgr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_n |-> clkmgr_rst_n);

  // R3: core release implies lock was seen two edges earlier
  p_lock_two_flop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_n |-> $past(lock_in, 2));

  // R4: strobe lasts exactly one cycle
  p_sync_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse);

  // R4: strobe only follows a write of 1 to the sync word
  p_sync_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |-> $past(wr_en && addr[11:2] == 10'h011 && wdata0));

  // R10: read valid follows the read strobe by one edge
  p_rvalid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);

  p_rvalid_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rvalid);
endmodule

bind dac_ctrl_regs dac_ctrl_regs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .addr        (addr),
  .wdata0      (wdata[0]),
  .lock_in     (lock_in),
  .clkmgr_rst_n(clkmgr_rst_n),
  .core_rst_n  (core_rst_n),
  .sync_pulse  (sync_pulse),
  .rvalid      (rvalid)
);

// File: tb/dac_ctrl_regs_tb.sv
module dac_ctrl_regs_tb;
  localparam int NUM_CH = 4;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  wr_en = 1'b0;
  logic                  rd_en = 1'b0;
  logic [11:0]           addr = '0;
  logic [31:0]           wdata = '0;
  logic [31:0]           rdata;
  logic                  rvalid;
  logic                  lock_in = 1'b0;
  logic                  clkmgr_rst_n, core_rst_n, sync_pulse, indep_mode;
  logic [NUM_CH*4-1:0]   ch_data_sel;
  logic [NUM_CH*128-1:0] ch_tone;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dac_ctrl_regs #(.NUM_CH(NUM_CH), .TONE_ABSENT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .lock_in(lock_in),
    .clkmgr_rst_n(clkmgr_rst_n), .core_rst_n(core_rst_n),
    .sync_pulse(sync_pulse), .indep_mode(indep_mode),
    .ch_data_sel(ch_data_sel), .ch_tone(ch_tone)
  );

  // {address, write data, expected readback}
  localparam int NV = 11;
  localparam logic [75:0] VEC [NV] = '{
    {12'h400, 32'hA5A5_0001, 32'hA5A5_0001},  // R7 ch0 word0
    {12'h404, 32'h0BAD_F00D, 32'h0BAD_F00D},  // R7 ch0 word1
    {12'h44C, 32'h1357_9BDF, 32'h1357_9BDF},  // R7 ch1 word3
    {12'h4C8, 32'hCAFE_0042, 32'hCAFE_0042},  // R7 ch3 word2
    {12'h418, 32'hFFFF_FFF2, 32'h0000_0002},  // R8 ch0 select stream
    {12'h458, 32'h0000_0000, 32'h0000_0000},  // R8 ch1 select tone
    {12'h00C, 32'hFFFF_FFFF, 32'h0000_0040},  // R6 read-only config
    {12'h048, 32'hFFFF_FFFF, 32'h0000_0010},  // R5 mode bit
    {12'h100, 32'hDEAD_BEEF, 32'h0000_0000},  // R9 unmapped global
    {12'h500, 32'h1234_5678, 32'h0000_0000},  // R9 channel beyond NUM_CH
    {12'h410, 32'h0000_1111, 32'h0000_0000}   // R9 window gap
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    chk("R10 rvalid on read", 32'(rvalid), 32'd1);
    rd_en = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 clkmgr_rst_n", 32'(clkmgr_rst_n), 32'd0);
    chk("R1 core_rst_n", 32'(core_rst_n), 32'd0);
    chk("R1 sync_pulse", 32'(sync_pulse), 32'd0);
    chk("R1 indep_mode", 32'(indep_mode), 32'd0);
    chk("R1 ch_data_sel", 32'(ch_data_sel), 32'd0);
    chk("R10 rvalid idle", 32'(rvalid), 32'd0);
    rd(12'h040, r); chk("R1 reset word", r, 32'd0);
    rd(12'h4C8, r); chk("R1 tone word", r, 32'd0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      rd(VEC[i][75:64], r);
      chk($sformatf("vector %0d readback", i), r, VEC[i][31:0]);
    end
    rd(12'h400, r); chk("R9 no alias into ch0", r, 32'hA5A5_0001);
    chk("R7 ch_tone ch0 w0", ch_tone[0 +: 32], 32'hA5A5_0001);
    chk("R7 ch_tone ch3 w2", ch_tone[(3*4+2)*32 +: 32], 32'hCAFE_0042);
    chk("R8 sel ch0 stream", 32'(ch_data_sel[3:0]), 32'd2);
    chk("R8 sel ch1 tone", 32'(ch_data_sel[7:4]), 32'd0);
    chk("R5 indep_mode", 32'(indep_mode), 32'd1);

    // R2 / R3 bring-up with lock low
    wr(12'h040, 32'h2);
    chk("R2 clkmgr released", 32'(clkmgr_rst_n), 32'd1);
    chk("R2 core held", 32'(core_rst_n), 32'd0);
    wr(12'h040, 32'hFFFF_FFFF);
    chk("R2 core held without lock", 32'(core_rst_n), 32'd0);
    rd(12'h040, r); chk("R2 reset word bits", r, 32'd3);
    rd(12'h074, r); chk("R3 status unlocked", r, 32'd0);
    lock_in = 1'b1;
    @(negedge clk);
    chk("R3 one edge after lock", 32'(core_rst_n), 32'd0);
    @(negedge clk);
    chk("R3 two edges after lock", 32'(core_rst_n), 32'd1);
    rd(12'h074, r); chk("R3 status locked", r, 32'h0002_0000);
    lock_in = 1'b0;
    @(negedge clk);
    chk("R3 lock loss first edge", 32'(core_rst_n), 32'd1);
    @(negedge clk);
    chk("R3 lock loss second edge", 32'(core_rst_n), 32'd0);
    lock_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 core released", 32'(core_rst_n), 32'd1);
    wr(12'h040, 32'h0);
    chk("R2 write 0 core", 32'(core_rst_n), 32'd0);
    chk("R2 write 0 clkmgr", 32'(clkmgr_rst_n), 32'd0);

    // R4 sync strobe
    wr(12'h044, 32'h1);
    chk("R4 pulse after write", 32'(sync_pulse), 32'd1);
    @(negedge clk);
    chk("R4 pulse one cycle", 32'(sync_pulse), 32'd0);
    rd(12'h044, r); chk("R4 self clear readback", r, 32'd0);
    wr(12'h044, 32'hFFFF_FFFE);
    chk("R4 no pulse for 0", 32'(sync_pulse), 32'd0);

    // R5 clear mode
    wr(12'h048, 32'hFFFF_FFEF);
    chk("R5 mode cleared", 32'(indep_mode), 32'd0);
    @(negedge clk);
    chk("R10 rvalid idle after reads", 32'(rvalid), 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule